// File: doc/BRIEF.md
# Timer Compare and Capture Channel

A free-running counter with two output-compare channels and one input-capture channel. Each compare channel keeps a timer output level that changes when the counter equals that channel's compare value, or on every cycle while the channel's force bit is set. A pin-enable bit decides only what each output pin shows: the timer level when it is set, a general-purpose value from the mode register when it is clear. The compare logic keeps running either way.

The capture input is synchronized, and its selected edge copies the counter into a capture register. Two extra modes drive output pin 1 from both channels. In PWM mode the counter reloads at compare 2. In one-pulse mode a capture edge restarts the counter and starts a pulse, which compare 1 ends. Sticky flags record matches and captures, and one enable bit routes them to an interrupt output. Software reaches every register through simple read and write strobes.

Top module: `tmr_cc_unit`

## Requirements
- R1: After reset, the control and mode registers read 0, the counter and the status read 0, both pins are 0 and irq_o is 0. Reset takes the compare registers to all ones.
- R2: Outside the two special modes, a cycle in which the counter runs and equals compare 1 copies control bit 1 (level 1) into the channel-1 timer level. The new level shows on cmp1_pin_o from the next clock edge.
- R3: A cycle in which the counter runs and equals compare 2 copies control bit 2 (level 2) into the channel-2 timer level, which shows on cmp2_pin_o from the next edge. This holds in every mode.
- R4: Control bits 5 and 6 enable pins 1 and 2. While an enable is 0, its pin shows mode bit 3 (pin 1) or mode bit 4 (pin 2). Matching, forcing, the flags and the timer level behave the same whatever the enable value, and the kept level appears on the pin once the enable is set.
- R5: While control bit 3 (channel 1) or control bit 4 (channel 2) is set, that channel's level bit is loaded into its timer level at every clock edge, with or without a match. The result reaches the pin only while the pin's enable is set.
- R6: Control bit 0 selects the capture edge: 0 captures on a falling edge, 1 on a rising edge. The input passes through two synchronizing flops. The capture register (address 4) and status bit 2 update at the third clock edge after the input changes, and the counter value is captured even while the counter is stopped.
- R7: With mode bit 0 set, the counter (address 5) increments at each clock edge and wraps at 2^CNT_W. With mode bit 0 clear it holds its value.
- R8: In PWM mode (mode bit 1), a compare-2 match reloads the counter to 0 at the next edge, so a period lasts compare 2 + 1 cycles. Pin 1 takes level 1 after a compare-1 match and level 2 after a compare-2 match. If both match in the same cycle, compare 1 wins.
- R9: In one-pulse mode (mode bit 2) with the counter running, the selected capture edge resets the counter to 0 and sets pin 1 to level 1 at the same edge. The later compare-1 match sets pin 1 to level 2.
- R10: Status bit 0 records compare-1 matches, bit 1 compare-2 matches and bit 2 captures. A bit stays set until a write to address 6 that has a 1 in that bit position. A new event in the same cycle as the clear keeps the bit set.
- R11: irq_o is 1 exactly when control bit 7 is set and at least one status bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Write address: 0 control, 1 mode, 2 compare 1, 3 compare 2, 6 status clear |
| wr_data_i | input | CNT_W | Write data |
| rd_addr_i | input | 3 | Read address: 0 to 3 as for writes, 4 capture, 5 counter, 6 status |
| rd_data_o | output | CNT_W | Read data, combinational from rd_addr_i |
| cap_i | input | 1 | Asynchronous capture input |
| cmp1_pin_o | output | 1 | Output pin of channel 1 |
| cmp2_pin_o | output | 1 | Output pin of channel 2 |
| irq_o | output | 1 | Interrupt request |

## Verification
Most internal state in this block shows up at a port within one or two edges. A wrong timer level appears on the pins as soon as the pin enable is set, and a wrong counter step moves every later match by a fixed number of cycles, so the bench checks pin transitions at exact cycle numbers that it works out from the cycles of its own writes. An extra or missing synchronizer stage moves the capture flag by one edge and changes the captured value, so captures are tested with the counter stopped and with the flag sampled on both sides of the expected edge. A force bit that leaks past a clear pin enable, or a restart that fails in one-pulse mode, changes the pin or the counter value in the cycle the bench samples.

// File: rtl/tmr_cc_pkg.sv
package tmr_cc_pkg;
  localparam int ADDR_W = 3;
  localparam int CTRL_W = 8;
  localparam int MODE_W = 5;
  localparam int FLAG_N = 3;
  localparam int FL_CMP1 = 0;
  localparam int FL_CMP2 = 1;
  localparam int FL_CAP  = 2;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL = 3'd0,
    A_MODE = 3'd1,
    A_CMP1 = 3'd2,
    A_CMP2 = 3'd3,
    A_CAP  = 3'd4,
    A_CNT  = 3'd5,
    A_STAT = 3'd6
  } reg_addr_e;

  typedef struct packed {
    logic irq_en;
    logic pen2;
    logic pen1;
    logic frc2;
    logic frc1;
    logic lvl2;
    logic lvl1;
    logic cap_rise;
  } ctrl_t;

  typedef struct packed {
    logic gpio2;
    logic gpio1;
    logic opm;
    logic pwm;
    logic cnt_en;
  } mode_t;
endpackage

// File: rtl/tmr_cc_count.sv
module tmr_cc_count #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         pwm_i,
  input  logic         restart_i,
  input  logic [W-1:0] cmp1_i,
  input  logic [W-1:0] cmp2_i,
  output logic [W-1:0] cnt_o,
  output logic         m1_o,
  output logic         m2_o
);
  logic [W-1:0] cnt_q;

  assign m1_o  = en_i && (cnt_q == cmp1_i);
  assign m2_o  = en_i && (cnt_q == cmp2_i);
  assign cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (en_i) begin
      if ((pwm_i && m2_o) || restart_i) cnt_q <= '0;
      else                              cnt_q <= cnt_q + 1'b1;
    end
  end

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(cnt_q));
  p_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !(pwm_i && m2_o) && !restart_i) |=> cnt_q == W'($past(cnt_q) + 1'b1));
  p_reload_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwm_i && m2_o) |=> cnt_q == '0);
  p_restart_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && restart_i) |=> cnt_q == '0);
endmodule

// File: rtl/tmr_cc_capture.sv
module tmr_cc_capture #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cap_i,
  input  logic         rise_sel_i,
  input  logic [W-1:0] cnt_i,
  output logic         evt_o,
  output logic [W-1:0] cap_o
);
  logic [2:0]   sync_q;  // [0],[1] synchronizer, [2] previous sample
  logic [W-1:0] cap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[1:0], cap_i};
  end

  assign evt_o = rise_sel_i ? (sync_q[1] & ~sync_q[2]) : (~sync_q[1] & sync_q[2]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cap_q <= '0;
    else if (evt_o) cap_q <= cnt_i;
  end

  assign cap_o = cap_q;

  p_latch_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o |=> cap_q == $past(cnt_i));
  p_keep_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !evt_o |=> $stable(cap_q));
endmodule

// File: rtl/tmr_cc_wave.sv
module tmr_cc_wave (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl1_i,
  input  logic lvl2_i,
  input  logic frc1_i,
  input  logic frc2_i,
  input  logic pwm_i,
  input  logic opm_i,
  input  logic m1_i,
  input  logic m2_i,
  input  logic start_i,
  output logic tq1_o,
  output logic tq2_o
);
  logic tq1_q, tq2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          tq1_q <= 1'b0;
    else if (frc1_i)      tq1_q <= lvl1_i;
    else if (opm_i) begin
      if (start_i)        tq1_q <= lvl1_i;
      else if (m1_i)      tq1_q <= lvl2_i;
    end else if (pwm_i) begin
      if (m1_i)           tq1_q <= lvl1_i;
      else if (m2_i)      tq1_q <= lvl2_i;
    end else if (m1_i)    tq1_q <= lvl1_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          tq2_q <= 1'b0;
    else if (frc2_i || m2_i) tq2_q <= lvl2_i;
  end

  assign tq1_o = tq1_q;
  assign tq2_o = tq2_q;

  p_force1_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frc1_i |=> tq1_q == $past(lvl1_i));
  p_force2_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frc2_i |=> tq2_q == $past(lvl2_i));
  p_cmp1_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m1_i && !frc1_i && !opm_i) |=> tq1_q == $past(lvl1_i));
  p_cmp2_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m2_i |=> tq2_q == $past(lvl2_i));
  p_start_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (opm_i && start_i && !frc1_i) |=> tq1_q == $past(lvl1_i));
endmodule

// File: rtl/tmr_cc_pin.sv
module tmr_cc_pin (
  input  logic en_i,
  input  logic tq_i,
  input  logic gpio_i,
  output logic pin_o
);
  assign pin_o = en_i ? tq_i : gpio_i;
endmodule

// File: rtl/tmr_cc_unit.sv
module tmr_cc_unit
  import tmr_cc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [2:0]       wr_addr_i,
  input  logic [CNT_W-1:0] wr_data_i,
  input  logic [2:0]       rd_addr_i,
  output logic [CNT_W-1:0] rd_data_o,
  input  logic             cap_i,
  output logic             cmp1_pin_o,
  output logic             cmp2_pin_o,
  output logic             irq_o
);
  localparam int CTRL_PAD = CNT_W - CTRL_W;
  localparam int MODE_PAD = CNT_W - MODE_W;
  localparam int FLAG_PAD = CNT_W - FLAG_N;
  localparam int PIN_N    = 2;

  ctrl_t             ctrl_q;
  mode_t             mode_q;
  logic [CNT_W-1:0]  cmp1_q, cmp2_q, cnt_w, cap_w;
  logic [FLAG_N-1:0] flag_q, flag_d;
  logic              m1_w, m2_w, evt_w, tq1_w, tq2_w;
  logic [PIN_N-1:0]  pen_w, tq_w, gpio_w, pin_w;
  reg_addr_e         wa, ra;

  assign wa = reg_addr_e'(wr_addr_i);
  assign ra = reg_addr_e'(rd_addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      mode_q <= '0;
      cmp1_q <= '1;
      cmp2_q <= '1;
    end else if (wr_en_i) begin
      case (wa)
        A_CTRL:  ctrl_q <= ctrl_t'(wr_data_i[CTRL_W-1:0]);
        A_MODE:  mode_q <= mode_t'(wr_data_i[MODE_W-1:0]);
        A_CMP1:  cmp1_q <= wr_data_i;
        A_CMP2:  cmp2_q <= wr_data_i;
        default: ;
      endcase
    end
  end

  tmr_cc_count #(.W(CNT_W)) u_count (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (mode_q.cnt_en),
    .pwm_i     (mode_q.pwm),
    .restart_i (mode_q.opm & evt_w),
    .cmp1_i    (cmp1_q),
    .cmp2_i    (cmp2_q),
    .cnt_o     (cnt_w),
    .m1_o      (m1_w),
    .m2_o      (m2_w)
  );

  tmr_cc_capture #(.W(CNT_W)) u_capture (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cap_i      (cap_i),
    .rise_sel_i (ctrl_q.cap_rise),
    .cnt_i      (cnt_w),
    .evt_o      (evt_w),
    .cap_o      (cap_w)
  );

  tmr_cc_wave u_wave (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .lvl1_i  (ctrl_q.lvl1),
    .lvl2_i  (ctrl_q.lvl2),
    .frc1_i  (ctrl_q.frc1),
    .frc2_i  (ctrl_q.frc2),
    .pwm_i   (mode_q.pwm),
    .opm_i   (mode_q.opm),
    .m1_i    (m1_w),
    .m2_i    (m2_w),
    .start_i (evt_w & mode_q.cnt_en),
    .tq1_o   (tq1_w),
    .tq2_o   (tq2_w)
  );

  assign pen_w  = {ctrl_q.pen2, ctrl_q.pen1};
  assign tq_w   = {tq2_w, tq1_w};
  assign gpio_w = {mode_q.gpio2, mode_q.gpio1};

  for (genvar i = 0; i < PIN_N; i++) begin : g_pin
    tmr_cc_pin u_pin (
      .en_i   (pen_w[i]),
      .tq_i   (tq_w[i]),
      .gpio_i (gpio_w[i]),
      .pin_o  (pin_w[i])
    );
  end

  assign cmp1_pin_o = pin_w[0];
  assign cmp2_pin_o = pin_w[1];

  // set beats a clear written in the same cycle
  always_comb begin
    flag_d = flag_q;
    if (wr_en_i && wa == A_STAT) flag_d = flag_d & ~wr_data_i[FLAG_N-1:0];
    flag_d[FL_CMP1] = flag_d[FL_CMP1] | m1_w;
    flag_d[FL_CMP2] = flag_d[FL_CMP2] | m2_w;
    flag_d[FL_CAP]  = flag_d[FL_CAP]  | evt_w;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= flag_d;
  end

  assign irq_o = ctrl_q.irq_en & (|flag_q);

  always_comb begin
    case (ra)
      A_CTRL:  rd_data_o = {{CTRL_PAD{1'b0}}, ctrl_q};
      A_MODE:  rd_data_o = {{MODE_PAD{1'b0}}, mode_q};
      A_CMP1:  rd_data_o = cmp1_q;
      A_CMP2:  rd_data_o = cmp2_q;
      A_CAP:   rd_data_o = cap_w;
      A_CNT:   rd_data_o = cnt_w;
      A_STAT:  rd_data_o = {{FLAG_PAD{1'b0}}, flag_q};
      default: rd_data_o = '0;
    endcase
  end

  p_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q[FL_CMP1] && !(wr_en_i && wa == A_STAT && wr_data_i[FL_CMP1])) |=> flag_q[FL_CMP1]);
  p_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wa == A_STAT && wr_data_i[FL_CAP] && !evt_w) |=> !flag_q[FL_CAP]);
  p_evt_flag_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m2_w |=> flag_q[FL_CMP2]);
  p_irq_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_q.irq_en && flag_q != '0) |-> irq_o);
endmodule

// File: tb/tmr_cc_unit_test.sv
`timescale 1ns/10ps
module tmr_cc_unit_test;
  localparam int W = 16;
  localparam logic [2:0] AC = 3'd0, AM = 3'd1, A1 = 3'd2, A2 = 3'd3,
                         AP = 3'd4, AN = 3'd5, AS = 3'd6;
  localparam int SEL_RD = 0, SEL_P1 = 1, SEL_P2 = 2, SEL_IRQ = 3;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic wr_en = 1'b0, cap = 1'b0;
  logic [2:0] wr_addr = '0, rd_addr = '0;
  logic [W-1:0] wr_data = '0, rd_data;
  logic pin1, pin2, irq;

  int cyc = 0, checks = 0, fails = 0, last_w = 0, e0 = 0;
  bit done = 1'b0;

  typedef struct { string req; int sel; logic [2:0] addr; logic [W-1:0] exp; } item_t;
  item_t sb_q[$];
  event  push_ev;

  tmr_cc_unit #(.CNT_W(W)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data), .cap_i(cap),
    .cmp1_pin_o(pin1), .cmp2_pin_o(pin2), .irq_o(irq)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // monitor: pops expectations and compares with the ports
  initial forever begin
    @(push_ev);
    while (sb_q.size() > 0) begin
      item_t it;
      logic [W-1:0] act;
      it = sb_q.pop_front();
      case (it.sel)
        SEL_P1:  act = W'(pin1);
        SEL_P2:  act = W'(pin2);
        SEL_IRQ: act = W'(irq);
        default: act = rd_data;
      endcase
      checks++;
      if (act !== it.exp) begin
        fails++;
        $display("FAIL %s sel=%0d addr=%0d cyc=%0d actual=%h expected=%h",
                 it.req, it.sel, it.addr, cyc, act, it.exp);
      end
    end
  end

  task automatic chk(input string req, input int sel, input logic [2:0] addr, input logic [W-1:0] exp);
    item_t it;
    rd_addr = addr;
    #0.2;
    it.req = req; it.sel = sel; it.addr = addr; it.exp = exp;
    sb_q.push_back(it);
    -> push_ev;
    #0.2;
  endtask

  task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    #1;
    wr_en = 1'b0;
    last_w = cyc;
  endtask

  task automatic upto(input int t);
    while (cyc < t) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic drive_cap(input logic v);
    @(negedge clk);
    cap = v;
    e0 = cyc;
  endtask

  initial begin
    repeat (10000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired at cyc=%0d actual=hung expected=finished", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int w_on, x_off, cnt_exp, p_on, d1, d2;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_ni = 1'b1;
    @(posedge clk); #1;

    // R1 reset state
    chk("R1", SEL_RD, AC, '0);
    chk("R1", SEL_RD, AM, '0);
    chk("R1", SEL_RD, AN, '0);
    chk("R1", SEL_RD, AS, '0);
    chk("R1", SEL_RD, A1, 16'hFFFF);
    chk("R1", SEL_P1, AC, 0);
    chk("R1", SEL_P2, AC, 0);
    chk("R1", SEL_IRQ, AC, 0);

    // R4 released pin shows gpio value
    wr(AM, 16'h0008);
    chk("R4", SEL_P1, AC, 1);
    chk("R4", SEL_P2, AC, 0);

    // R5 force with pin enabled
    wr(AC, 16'h002A);
    upto(last_w + 1);
    chk("R5", SEL_P1, AC, 1);
    wr(AC, 16'h0028);
    upto(last_w + 1);
    chk("R5", SEL_P1, AC, 0);

    // R5/R4 force with pin released: pin stays gpio, level still kept
    wr(AM, 16'h0000);
    wr(AC, 16'h000A);
    upto(last_w + 2);
    chk("R5", SEL_P1, AC, 0);
    wr(AC, 16'h0020);
    chk("R4", SEL_P1, AC, 1);

    wr(AC, 16'h0054);
    upto(last_w + 1);
    chk("R5", SEL_P2, AC, 1);
    wr(AC, 16'h0050);
    upto(last_w + 1);
    chk("R5", SEL_P2, AC, 0);

    // R2/R3 compare, pin 2 released during match
    wr(A1, 16'd5);
    wr(A2, 16'd9);
    wr(AC, 16'h0024);
    wr(AS, 16'h0007);
    chk("R10", SEL_RD, AS, '0);
    wr(AM, 16'h0001);
    w_on = last_w;
    upto(w_on + 5);
    chk("R2", SEL_P1, AC, 1);
    chk("R10", SEL_RD, AS, '0);
    upto(w_on + 6);
    chk("R2", SEL_P1, AC, 0);
    chk("R10", SEL_RD, AS, 16'h0001);
    upto(w_on + 9);
    chk("R3", SEL_RD, AS, 16'h0001);
    upto(w_on + 10);
    chk("R4", SEL_P2, AC, 0);
    chk("R3", SEL_RD, AS, 16'h0003);
    chk("R7", SEL_RD, AN, W'(cyc - w_on));
    wr(AC, 16'h0064);
    chk("R3", SEL_P2, AC, 1);

    // R11 interrupt and R10 write-one-to-clear
    chk("R11", SEL_IRQ, AC, 0);
    wr(AC, 16'h00E4);
    chk("R11", SEL_IRQ, AC, 1);
    wr(AS, 16'h0001);
    chk("R10", SEL_RD, AS, 16'h0002);
    chk("R11", SEL_IRQ, AC, 1);
    wr(AS, 16'h0002);
    chk("R10", SEL_RD, AS, '0);
    chk("R11", SEL_IRQ, AC, 0);

    // R7 stop counter and hold
    wr(AM, 16'h0000);
    x_off = last_w;
    cnt_exp = x_off - w_on;
    upto(x_off + 3);
    chk("R7", SEL_RD, AN, W'(cnt_exp));

    // R6 falling edge selected: rising ignored
    drive_cap(1'b1);
    upto(e0 + 4);
    chk("R6", SEL_RD, AS, '0);
    chk("R6", SEL_RD, AP, '0);
    drive_cap(1'b0);
    upto(e0 + 2);
    chk("R6", SEL_RD, AS, '0);
    upto(e0 + 3);
    chk("R6", SEL_RD, AS, 16'h0004);
    chk("R6", SEL_RD, AP, W'(cnt_exp));
    chk("R11", SEL_IRQ, AC, 1);
    wr(AS, 16'h0004);
    chk("R10", SEL_RD, AS, '0);

    // R6 rising edge selected
    wr(AC, 16'h00E5);
    drive_cap(1'b1);
    upto(e0 + 2);
    chk("R6", SEL_RD, AS, '0);
    upto(e0 + 3);
    chk("R6", SEL_RD, AS, 16'h0004);
    chk("R6", SEL_RD, AP, W'(cnt_exp));
    wr(AS, 16'h0007);

    // R8 PWM
    wr(A1, 16'd100);
    wr(A2, 16'd149);
    wr(AC, 16'h0022);
    wr(AM, 16'h0003);
    p_on = last_w;
    d1 = 100 - cnt_exp;
    d2 = 149 - cnt_exp;
    upto(p_on + d1);
    chk("R8", SEL_P1, AC, 0);
    upto(p_on + d1 + 1);
    chk("R8", SEL_P1, AC, 1);
    upto(p_on + d2 + 1);
    chk("R8", SEL_P1, AC, 0);
    chk("R8", SEL_RD, AN, '0);
    upto(p_on + d2 + 101);
    chk("R8", SEL_P1, AC, 0);
    upto(p_on + d2 + 102);
    chk("R8", SEL_P1, AC, 1);
    upto(p_on + d2 + 151);
    chk("R8", SEL_RD, AN, '0);
    chk("R8", SEL_P1, AC, 0);

    // R9 one-pulse, rising edge selected
    wr(AC, 16'h0023);
    wr(A1, 16'd6);
    wr(AM, 16'h0005);
    drive_cap(1'b0);
    upto(e0 + 4);
    drive_cap(1'b1);
    upto(e0 + 3);
    chk("R9", SEL_RD, AN, '0);
    chk("R9", SEL_P1, AC, 1);
    upto(e0 + 9);
    chk("R9", SEL_P1, AC, 1);
    upto(e0 + 10);
    chk("R9", SEL_P1, AC, 0);
    chk("R9", SEL_RD, AN, 16'd7);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule